// File: doc/BRIEF.md
# PN Despreading Correlator Bank

This block despreads the outputs of a pulse-matched filter against a pseudo-noise (PN) chip sequence. A row of parallel correlators, one per window offset, shares a single chip stream. On every chip each enabled correlator adds its own input sample when the current chip is 1 and subtracts it when the chip is 0. The chip bits sit in an on-block code store. A write port loads the store, and an address counter steps through it, one location per chip.

The sequence length can be set anywhere from 1 to 1024 chips. When the chip at the final address of the sequence has been taken in, every correlator's complete sum is presented together with a one-cycle dump pulse. The accumulators then start the next period from zero. A separate symbol strobe marks the chip whose address matches a programmable phase value, so downstream tracking logic can place symbol boundaries.

Each correlator has its own enable so that unused search offsets can be gated off. A disabled correlator keeps both its running sum and its last dumped total. With the default size of eleven lanes the block covers a partial parallel search.

Top module: `pn_despread_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `chip_addr` is 0, `dump_valid` and `sym_strobe` are 0, and every lane of `dump_totals` is 0.
- R2: Each cycle with `chip_valid` high advances `chip_addr` by one. After the last chip (address `pn_len`-1, for `pn_len` from 1 to 1024) it returns to 0. A cycle with `chip_valid` low leaves `chip_addr` unchanged.
- R3: A cycle with `code_we` high stores `code_wdata` at location `code_waddr` of the code store. The chip applied on a `chip_valid` cycle is the stored bit at the current `chip_addr`.
- R4: Lane k takes the two's-complement sample `samples[k*IN_W +: IN_W]`. On each chip it adds the sample when the chip bit is 1 and subtracts it when the chip bit is 0.
- R5: In the cycle after the chip at address `pn_len`-1, `dump_valid` is high for one cycle. Each enabled lane of `dump_totals` then equals the signed sum over the whole period, including that last chip. The next period starts from a sum of zero.
- R6: Each lane of `dump_totals` is IN_W+10 bits wide, two's complement, at bits `[k*ACC_W +: ACC_W]`. It represents 1024 chips of a full-scale negative or maximum positive sample without overflow.
- R7: `sym_strobe` is high for exactly one cycle, the cycle after a `chip_valid` cycle in which `chip_addr` equals `strobe_phase`. A phase at or beyond the sequence length never fires.
- R8: While `lane_en[k]` is low, lane k ignores chips. Its running sum is frozen and resumes from the same value when it is enabled again. Its `dump_totals` lane keeps its previous value, even at a dump.
- R9: Between dumps, `dump_totals` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_valid | input | 1 | One chip is processed this cycle |
| samples | input | NCORR*IN_W | Packed signed matched-filter samples, lane k at `[k*IN_W +: IN_W]` |
| lane_en | input | NCORR | Per-lane enable, bit k gates lane k |
| pn_len | input | LEN_W | Sequence length in chips, 1 to 1024 |
| strobe_phase | input | ADDR_W | Chip address that raises the symbol strobe |
| code_we | input | 1 | Code store write enable |
| code_waddr | input | ADDR_W | Code store write address |
| code_wdata | input | 1 | Chip bit to store |
| chip_addr | output | ADDR_W | Address of the next chip to be read |
| sym_strobe | output | 1 | Symbol boundary pulse |
| dump_valid | output | 1 | Period totals valid this cycle |
| dump_totals | output | NCORR*ACC_W | Packed signed period totals, lane k at `[k*ACC_W +: ACC_W]` |

## Verification
The assertions assume that `pn_len` and `strobe_phase` change only while `rst` is high or between whole periods. They also assume the code store is not written while chips are flowing. The bench follows both rules: it resets and reloads the store before each configuration, and it changes lane enables and samples only at chip boundaries. It drives every length at or below the store depth, so the clamping of out-of-range lengths is never exercised.

// File: rtl/pnb_pkg.sv
package pnb_pkg;

    localparam int unsigned ACC_GUARD = 10;

    // Information carried from the address/code side to every lane.
    typedef struct packed {
        logic valid;   // a chip is processed this cycle
        logic chip;    // PN chip bit: 1 adds, 0 subtracts
        logic last;    // final chip of the period
    } chip_step_t;

    // Index of the final chip for a requested length, kept inside the store.
    function automatic int unsigned last_chip(input int unsigned len,
                                              input int unsigned depth);
        if (len == 0)
            return 0;
        else if (len > depth)
            return depth - 1;
        else
            return len - 1;
    endfunction

endpackage

// File: rtl/pnb_code_store.sv
module pnb_code_store #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we)
            bits_q[waddr] <= wdata;
    end

    assign rdata = bits_q[raddr];

endmodule

// File: rtl/pnb_addr_ctr.sv
module pnb_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic [AW-1:0] last_idx,
    input  logic [AW-1:0] phase,
    output logic [AW-1:0] addr_o,
    output logic          at_last,
    output logic          sym_o
);

    logic [AW-1:0] addr_q;

    // A length cut below the current address still wraps cleanly.
    assign at_last = (addr_q >= last_idx);
    assign addr_o  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            sym_o  <= 1'b0;
        end else begin
            sym_o <= advance && (addr_q == phase);
            if (advance)
                addr_q <= at_last ? '0 : addr_q + 1'b1;
        end
    end

endmodule

// File: rtl/pnb_corr_lane.sv
module pnb_corr_lane #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 18,
    localparam int EXT  = ACC_W - IN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pnb_pkg::chip_step_t      step,
    input  logic                     en,
    input  logic signed [IN_W-1:0]   sample,
    output logic signed [ACC_W-1:0]  total_o
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] wide;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] next_sum;

    assign wide     = {{EXT{sample[IN_W-1]}}, sample};
    assign prod     = step.chip ? wide : -wide;
    assign next_sum = acc_q + prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            total_o <= '0;
        end else if (step.valid && en) begin
            if (step.last) begin
                total_o <= next_sum;
                acc_q   <= '0;
            end else begin
                acc_q   <= next_sum;
            end
        end
    end

endmodule

// File: rtl/pn_despread_bank.sv
module pn_despread_bank #(
    parameter int NCORR  = 11,
    parameter int IN_W   = 8,
    parameter int PN_MAX = 1024,
    localparam int ADDR_W = $clog2(PN_MAX),
    localparam int LEN_W  = $clog2(PN_MAX + 1),
    localparam int ACC_W  = IN_W + pnb_pkg::ACC_GUARD
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     chip_valid,
    input  logic [NCORR*IN_W-1:0]    samples,
    input  logic [NCORR-1:0]         lane_en,
    input  logic [LEN_W-1:0]         pn_len,
    input  logic [ADDR_W-1:0]        strobe_phase,
    input  logic                     code_we,
    input  logic [ADDR_W-1:0]        code_waddr,
    input  logic                     code_wdata,
    output logic [ADDR_W-1:0]        chip_addr,
    output logic                     sym_strobe,
    output logic                     dump_valid,
    output logic [NCORR*ACC_W-1:0]   dump_totals
);

    import pnb_pkg::*;

    logic [ADDR_W-1:0] last_idx;
    logic              at_last;
    logic              chip_bit;
    chip_step_t        step;

    assign last_idx = ADDR_W'(last_chip(32'(pn_len), PN_MAX));

    pnb_addr_ctr #(.AW(ADDR_W)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .advance  (chip_valid),
        .last_idx (last_idx),
        .phase    (strobe_phase),
        .addr_o   (chip_addr),
        .at_last  (at_last),
        .sym_o    (sym_strobe)
    );

    pnb_code_store #(.DEPTH(PN_MAX)) store_i (
        .clk   (clk),
        .we    (code_we),
        .waddr (code_waddr),
        .wdata (code_wdata),
        .raddr (chip_addr),
        .rdata (chip_bit)
    );

    assign step.valid = chip_valid;
    assign step.chip  = chip_bit;
    assign step.last  = at_last;

    for (genvar k = 0; k < NCORR; k++) begin : g_lane
        pnb_corr_lane #(.IN_W(IN_W), .ACC_W(ACC_W)) lane_i (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .en      (lane_en[k]),
            .sample  (samples[k*IN_W +: IN_W]),
            .total_o (dump_totals[k*ACC_W +: ACC_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            dump_valid <= 1'b0;
        else
            dump_valid <= chip_valid && at_last;
    end

endmodule

// File: rtl/pnb_checker.sv
module pnb_checker #(
    parameter int NCORR  = 11,
    parameter int IN_W   = 8,
    parameter int PN_MAX = 1024,
    localparam int ADDR_W = $clog2(PN_MAX),
    localparam int LEN_W  = $clog2(PN_MAX + 1),
    localparam int ACC_W  = IN_W + pnb_pkg::ACC_GUARD
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   chip_valid,
    input logic [NCORR-1:0]       lane_en,
    input logic [LEN_W-1:0]       pn_len,
    input logic [ADDR_W-1:0]      strobe_phase,
    input logic [ADDR_W-1:0]      chip_addr,
    input logic                   sym_strobe,
    input logic                   dump_valid,
    input logic [NCORR*ACC_W-1:0] dump_totals
);

    import pnb_pkg::*;

    logic [ADDR_W-1:0] lim;
    assign lim = ADDR_W'(last_chip(32'(pn_len), PN_MAX));

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) && !rst |-> chip_addr == '0 && !dump_valid && !sym_strobe && dump_totals == '0);

    // R2: idle cycles leave the address alone
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(chip_valid) && !$past(rst) |-> $stable(chip_addr));

    // R2: address wraps after the final chip
    a_r2_addr_wrap: assert property (@(posedge clk) disable iff (rst)
        $past(chip_valid) && !$past(rst) && $past(chip_addr) >= $past(lim) |-> chip_addr == '0);

    // R2: address steps by one inside the period
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        $past(chip_valid) && !$past(rst) && $past(chip_addr) < $past(lim)
        |-> chip_addr == $past(chip_addr) + 1'b1);

    // R5: a dump follows a processed chip and leaves the address at zero
    a_r5_dump_wrap: assert property (@(posedge clk) disable iff (rst)
        dump_valid |-> $past(chip_valid) && chip_addr == '0);

    // R7: the strobe follows a chip at the programmed phase
    a_r7_strobe_phase: assert property (@(posedge clk) disable iff (rst)
        sym_strobe |-> $past(chip_valid) && $past(chip_addr) == $past(strobe_phase));

    // R9: totals are held between dumps
    a_r9_hold_totals: assert property (@(posedge clk) disable iff (rst)
        !dump_valid && !$past(rst) |-> $stable(dump_totals));

    // R8: a lane disabled on the previous edge keeps its total
    for (genvar k = 0; k < NCORR; k++) begin : g_dis
        a_r8_disabled_hold: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && !$past(lane_en[k])
            |-> $stable(dump_totals[k*ACC_W +: ACC_W]));
    end

endmodule

bind pn_despread_bank pnb_checker #(.NCORR(NCORR), .IN_W(IN_W), .PN_MAX(PN_MAX)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .chip_valid   (chip_valid),
    .lane_en      (lane_en),
    .pn_len       (pn_len),
    .strobe_phase (strobe_phase),
    .chip_addr    (chip_addr),
    .sym_strobe   (sym_strobe),
    .dump_valid   (dump_valid),
    .dump_totals  (dump_totals)
);

// File: tb/pn_despread_bank_tb.sv
module pn_despread_bank_tb_top;

    localparam int NCORR  = 11;
    localparam int IN_W   = 8;
    localparam int PN_MAX = 1024;
    localparam int ADDR_W = $clog2(PN_MAX);
    localparam int LEN_W  = $clog2(PN_MAX + 1);
    localparam int ACC_W  = IN_W + 10;

    // Stimulus table: length, strobe phase, code pattern, sample base, chip balance.
    // Pattern 0 = all ones, 1 = ones at even addresses, 2 = all zeros.
    // Lane k sample = base + k; expected total = (base + k) * balance.
    localparam int NT = 6;
    localparam int T_LEN  [NT] = '{4, 5, 1, 7, 3, 6};
    localparam int T_PH   [NT] = '{2, 0, 0, 6, 5, 3};
    localparam int T_PAT  [NT] = '{1, 1, 0, 0, 1, 2};
    localparam int T_BASE [NT] = '{3, -5, 7, -2, 20, 4};
    localparam int T_BAL  [NT] = '{0, 1, 1, 7, 1, -6};

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   chip_valid;
    logic [NCORR*IN_W-1:0]  samples;
    logic [NCORR-1:0]       lane_en;
    logic [LEN_W-1:0]       pn_len;
    logic [ADDR_W-1:0]      strobe_phase;
    logic                   code_we;
    logic [ADDR_W-1:0]      code_waddr;
    logic                   code_wdata;
    logic [ADDR_W-1:0]      chip_addr;
    logic                   sym_strobe;
    logic                   dump_valid;
    logic [NCORR*ACC_W-1:0] dump_totals;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pn_despread_bank #(.NCORR(NCORR), .IN_W(IN_W), .PN_MAX(PN_MAX)) dut_i (
        .clk(clk), .rst(rst), .chip_valid(chip_valid), .samples(samples),
        .lane_en(lane_en), .pn_len(pn_len), .strobe_phase(strobe_phase),
        .code_we(code_we), .code_waddr(code_waddr), .code_wdata(code_wdata),
        .chip_addr(chip_addr), .sym_strobe(sym_strobe), .dump_valid(dump_valid),
        .dump_totals(dump_totals)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lane_total(input int k);
        logic signed [ACC_W-1:0] v;
        v = dump_totals[k*ACC_W +: ACC_W];
        return int'(v);
    endfunction

    task automatic set_lane(input int k, input int val);
        samples[k*IN_W +: IN_W] = IN_W'(val);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; chip_valid = 1'b0; code_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_code(input int pat, input int n);
        for (int a = 0; a < n; a++) begin
            code_we    = 1'b1;
            code_waddr = ADDR_W'(a);
            code_wdata = (pat == 0) ? 1'b1 : (pat == 2) ? 1'b0 : ((a % 2) == 0);
            @(negedge clk);
        end
        code_we = 1'b0;
    endtask

    task automatic chip_tick();
        chip_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; chip_valid = 1'b0; samples = '0; lane_en = '1;
        pn_len = LEN_W'(4); strobe_phase = '0;
        code_we = 1'b0; code_waddr = '0; code_wdata = 1'b0;

        // R1: reset state, sampled after release
        do_reset();
        chk("R1 addr", int'(chip_addr), 0);
        chk("R1 dump_valid", int'(dump_valid), 0);
        chk("R1 sym_strobe", int'(sym_strobe), 0);
        chk("R1 totals zero", int'(dump_totals == '0), 1);

        // Table walk: R2 R3 R4 R5 R7 over two back-to-back periods each
        for (int t = 0; t < NT; t++) begin
            pn_len = LEN_W'(T_LEN[t]);
            strobe_phase = ADDR_W'(T_PH[t]);
            lane_en = '1;
            for (int k = 0; k < NCORR; k++) set_lane(k, T_BASE[t] + k);
            do_reset();
            load_code(T_PAT[t], T_LEN[t]);
            for (int p = 0; p < 2; p++) begin
                for (int i = 0; i < T_LEN[t]; i++) begin
                    chip_tick();
                    chk("R2 addr step", int'(chip_addr), (i + 1) % T_LEN[t]);
                    chk("R5 dump pulse", int'(dump_valid), int'(i == T_LEN[t] - 1));
                    chk("R7 strobe", int'(sym_strobe), int'(i == T_PH[t]));
                end
                chip_valid = 1'b0;
                for (int k = 0; k < NCORR; k++)
                    chk("R4 R5 lane total", lane_total(k), (T_BASE[t] + k) * T_BAL[t]);
            end
        end

        // R2 R9: idle cycles hold address, strobe low, totals stable
        pn_len = LEN_W'(8); strobe_phase = ADDR_W'(7);
        for (int k = 0; k < NCORR; k++) set_lane(k, 1);
        do_reset();
        load_code(0, 8);
        for (int i = 0; i < 3; i++) chip_tick();
        chip_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R2 idle addr", int'(chip_addr), 3);
            chk("R9 idle totals", int'(dump_totals == '0), 1);
            chk("R7 idle strobe", int'(sym_strobe), 0);
        end

        // R8: lane gating, lane k sample = 10 + k, all-ones code, length 4
        pn_len = LEN_W'(4); strobe_phase = ADDR_W'(9);
        for (int k = 0; k < NCORR; k++) set_lane(k, 10 + k);
        lane_en = '1;
        do_reset();
        load_code(0, 4);
        for (int i = 0; i < 4; i++) begin
            lane_en = '1;
            lane_en[5] = 1'b0;
            if (i == 2) lane_en[2] = 1'b0;
            chip_tick();
        end
        chip_valid = 1'b0;
        chk("R8 lane2 skips one chip", lane_total(2), 36);
        chk("R8 lane5 disabled keeps total", lane_total(5), 0);
        chk("R8 lane0 unaffected", lane_total(0), 40);
        for (int i = 0; i < 4; i++) begin
            lane_en = '1;
            if (i == 3) lane_en[5] = 1'b0;
            chip_tick();
        end
        chip_valid = 1'b0;
        chk("R8 lane5 held at dump", lane_total(5), 0);
        chk("R8 lane2 full period", lane_total(2), 48);
        lane_en = '1;
        for (int i = 0; i < 4; i++) chip_tick();
        chip_valid = 1'b0;
        chk("R8 lane5 resumes frozen sum", lane_total(5), 105);

        // R6: 1024 chips at full-scale samples
        pn_len = LEN_W'(1024); strobe_phase = ADDR_W'(1023);
        samples = '0;
        set_lane(0, -128);
        set_lane(1, 127);
        lane_en = '1;
        do_reset();
        load_code(0, 1024);
        for (int i = 0; i < 1023; i++) chip_tick();
        chk("R2 addr before wrap", int'(chip_addr), 1023);
        chip_tick();
        chip_valid = 1'b0;
        chk("R5 dump at length 1024", int'(dump_valid), 1);
        chk("R7 strobe at phase 1023", int'(sym_strobe), 1);
        chk("R6 negative full scale", lane_total(0), -131072);
        chk("R6 positive full scale", lane_total(1), 130048);
        chk("R2 wrap to zero", int'(chip_addr), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule